// File: doc/BRIEF.md
# Per-Core Interrupt Acknowledge Interface

This block is the per-core front end of an interrupt controller. Each core reaches it through a single 32-bit register port that carries a core number with every access. For each core it holds an interface enable, a priority mask and a binary point. It keeps a record of the highest pending interrupt that an external arbiter has picked for that core, and drives that core's interrupt request line from this record. Priority arbitration and the distributor's pending, active and configuration storage sit outside the block.

Reading the acknowledge register has a side effect. If the global distributor enable and the core's own enable are both set, the read returns the recorded interrupt and the core number of its software source. The same read clears the record, drops the request line and asks the arbiter for a fresh decision. If either enable is clear, the read returns the spurious ID and changes nothing. An end-of-interrupt write sends a clear strobe toward the distributor:

- For a software interrupt, the strobe clears one bit of a 64-bit vector indexed by requesting core and source core.
- For any other interrupt, the strobe carries the interrupt ID so the distributor can drop its active state.

Every access returns a registered response one cycle later.

Top module: `cpuif_ack`

## Requirements
- R1: Per-core control (enable in bit 0, offset 0x00), priority mask (PRI_W bits, offset 0x04) and binary point (3 bits, offset 0x08) are written from the low bits of the write data. They read back zero-extended for the addressed core only.
- R2: Offset 0x1C reads as zero. Offset 0x14 returns the addressed core's slice of the run_pri input.
- R3: A read of offset 0x0C returns {source core in bits 12:10, ID in bits 9:0} of the core's record only when dist_en and that core's enable are both 1. Otherwise it returns 1023 and leaves record and request line unchanged.
- R4: A granted acknowledge sets the core's record to ID 1023 with source 0. In the next cycle irq_out for that core is 0 and reeval pulses.
- R5: A hp_load strobe for a core stores hp_id/hp_src in its record. In the next cycle irq_out for that core is 1 exactly when the ID is not 1023.
- R6: When a granted acknowledge and a hp_load hit the same core in one cycle, the read returns the old record and the acknowledge wins: the record becomes 1023 and irq_out is 0.
- R7: A write to offset 0x10 whose bits 9:0 are below 16 raises, in the next cycle, exactly one bit of sgi_clr_mask: bit (acc_core + 8 × bits 12:10). act_clr_vld stays 0.
- R8: A write to offset 0x10 whose ID is 16 or more raises act_clr_vld with act_clr_id equal to that ID in the next cycle. sgi_clr_mask stays 0.
- R9: A mapped write pulses reeval in the next cycle when the addressed core's enable, as it stands after the write, is 1. It does not pulse reeval when that enable is 0.
- R10: Offset 0x18, unmapped offsets, writes to 0x0C/0x14/0x1C and reads of 0x10 give rsp_err=1 and rsp_rdata=0. They change no state and raise no reeval or clear strobe.
- R11: After reset, irq_out, reeval, strobes and responses are 0, every register reads 0 and every record holds ID 1023.
- R12: rsp_valid is 1 exactly in the cycle after a cycle with acc_valid=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_en | input | 1 | Global distributor enable |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_core | input | CORE_W | Core issuing the access |
| acc_addr | input | ADDR_W | Byte offset of the register |
| acc_wdata | input | 32 | Write data |
| hp_load | input | NUM_CORES | Per-core strobe to load a new highest-pending record |
| hp_id | input | NUM_CORES*10 | Highest pending ID per core |
| hp_src | input | NUM_CORES*3 | Source core of that ID per core |
| run_pri | input | NUM_CORES*PRI_W | Running priority per core |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access error |
| irq_out | output | NUM_CORES | Interrupt request per core |
| reeval | output | 1 | Re-evaluation request pulse |
| sgi_clr_mask | output | 64 | One-hot clear of the software-interrupt pending vector |
| act_clr_vld | output | 1 | Active-clear strobe |
| act_clr_id | output | 10 | ID whose active bit is cleared |

## Verification
An acknowledge read and a new arbiter decision for the same core can land in the same cycle. The bench provokes this by raising hp_load for the acknowledging core in the access cycle. It expects the old record in the read data, a low request line afterwards and a spurious result from the next acknowledge. Random runs also mix loads with acknowledges on other cores and with dist_en toggling, and a reference model computes the response, strobes and request lines.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int ID_W     = 10;
  localparam int SRC_W    = 3;
  localparam int SRC_LSB  = 10;
  localparam int BPR_W    = 3;
  localparam int SGI_LIM  = 16;
  localparam logic [ID_W-1:0] SPUR_ID = 10'd1023;

  localparam logic [7:0] OFF_CTL   = 8'h00;
  localparam logic [7:0] OFF_PMR   = 8'h04;
  localparam logic [7:0] OFF_BPR   = 8'h08;
  localparam logic [7:0] OFF_ACK   = 8'h0C;
  localparam logic [7:0] OFF_EOI   = 8'h10;
  localparam logic [7:0] OFF_RPR   = 8'h14;
  localparam logic [7:0] OFF_IDENT = 8'h1C;

  typedef enum logic [2:0] {
    REG_NONE, REG_CTL, REG_PMR, REG_BPR, REG_ACK, REG_EOI, REG_RPR, REG_IDENT
  } reg_e;
endpackage

// File: rtl/cpuif_decode.sv
module cpuif_decode
  import cpuif_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output reg_e              sel,
  output logic              err
);
  always_comb begin
    sel = REG_NONE;
    err = 1'b0;
    case (addr)
      ADDR_W'(OFF_CTL):   sel = REG_CTL;
      ADDR_W'(OFF_PMR):   sel = REG_PMR;
      ADDR_W'(OFF_BPR):   sel = REG_BPR;
      ADDR_W'(OFF_ACK):   if (!wr) sel = REG_ACK;   else err = 1'b1;
      ADDR_W'(OFF_EOI):   if (wr)  sel = REG_EOI;   else err = 1'b1;
      ADDR_W'(OFF_RPR):   if (!wr) sel = REG_RPR;   else err = 1'b1;
      ADDR_W'(OFF_IDENT): if (!wr) sel = REG_IDENT; else err = 1'b1;
      default:            err = 1'b1;
    endcase
  end
endmodule

// File: rtl/cpuif_core_slot.sv
module cpuif_core_slot
  import cpuif_pkg::*;
#(
  parameter int PRI_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl,
  input  logic             wr_pmr,
  input  logic             wr_bpr,
  input  logic [PRI_W-1:0] wdata,
  input  logic             ack_take,
  input  logic             hp_load,
  input  logic [ID_W-1:0]  hp_id,
  input  logic [SRC_W-1:0] hp_src,
  output logic             en,
  output logic [PRI_W-1:0] pmr,
  output logic [BPR_W-1:0] bpr,
  output logic [ID_W-1:0]  rec_id,
  output logic [SRC_W-1:0] rec_src,
  output logic             irq
);
  logic             en_d;
  logic [PRI_W-1:0] pmr_d;
  logic [BPR_W-1:0] bpr_d;
  logic [ID_W-1:0]  id_d;
  logic [SRC_W-1:0] src_d;
  logic             irq_d;
  logic             rec_ce;

  always_comb begin
    en_d   = wr_ctl ? wdata[0] : en;
    pmr_d  = wr_pmr ? wdata : pmr;
    bpr_d  = wr_bpr ? wdata[BPR_W-1:0] : bpr;
    rec_ce = ack_take | hp_load;
    // acknowledge consumes the record and wins over a same-cycle load
    if (ack_take) begin
      id_d  = SPUR_ID;
      src_d = '0;
      irq_d = 1'b0;
    end else begin
      id_d  = hp_id;
      src_d = hp_src;
      irq_d = (hp_id != SPUR_ID);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      pmr     <= '0;
      bpr     <= '0;
      rec_id  <= SPUR_ID;
      rec_src <= '0;
      irq     <= 1'b0;
    end else begin
      en  <= en_d;
      pmr <= pmr_d;
      bpr <= bpr_d;
      if (rec_ce) begin
        rec_id  <= id_d;
        rec_src <= src_d;
        irq     <= irq_d;
      end
    end
  end
endmodule

// File: rtl/cpuif_eoi.sv
module cpuif_eoi
  import cpuif_pkg::*;
#(
  parameter int CORE_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     eoi_go,
  input  logic [CORE_W-1:0]        core,
  input  logic [SRC_LSB+SRC_W-1:0] wdata,
  output logic [63:0]              sgi_mask,
  output logic                     act_vld,
  output logic [ID_W-1:0]          act_id
);
  logic [ID_W-1:0]  id;
  logic [SRC_W-1:0] src;
  logic [5:0]       bit_idx;
  logic             is_sgi;
  logic [63:0]      mask_d;
  logic             act_d;
  logic [ID_W-1:0]  aid_d;

  always_comb begin
    id      = wdata[ID_W-1:0];
    src     = wdata[SRC_LSB +: SRC_W];
    is_sgi  = (id < ID_W'(SGI_LIM));
    // index = requesting core + 8 * source core
    bit_idx = {src, 3'(core)};
    mask_d  = (eoi_go && is_sgi) ? (64'd1 << bit_idx) : 64'd0;
    act_d   = eoi_go && !is_sgi;
    aid_d   = act_d ? id : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sgi_mask <= '0;
      act_vld  <= 1'b0;
      act_id   <= '0;
    end else begin
      sgi_mask <= mask_d;
      act_vld  <= act_d;
      act_id   <= aid_d;
    end
  end
endmodule

// File: rtl/cpuif_ack.sv
module cpuif_ack
  import cpuif_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int PRI_W     = 8,
  parameter int ADDR_W    = 8,
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dist_en,
  input  logic                          acc_valid,
  input  logic                          acc_write,
  input  logic [CORE_W-1:0]             acc_core,
  input  logic [ADDR_W-1:0]             acc_addr,
  input  logic [31:0]                   acc_wdata,
  input  logic [NUM_CORES-1:0]          hp_load,
  input  logic [NUM_CORES*ID_W-1:0]     hp_id,
  input  logic [NUM_CORES*SRC_W-1:0]    hp_src,
  input  logic [NUM_CORES*PRI_W-1:0]    run_pri,
  output logic                          rsp_valid,
  output logic [31:0]                   rsp_rdata,
  output logic                          rsp_err,
  output logic [NUM_CORES-1:0]          irq_out,
  output logic                          reeval,
  output logic [63:0]                   sgi_clr_mask,
  output logic                          act_clr_vld,
  output logic [ID_W-1:0]               act_clr_id
);
  localparam int PAD_W = 32 - ID_W - SRC_W;

  reg_e             sel;
  logic             dec_err;
  logic [NUM_CORES-1:0] en_v;
  logic [PRI_W-1:0] pmr_v  [NUM_CORES];
  logic [BPR_W-1:0] bpr_v  [NUM_CORES];
  logic [ID_W-1:0]  id_v   [NUM_CORES];
  logic [SRC_W-1:0] src_v  [NUM_CORES];
  logic [NUM_CORES-1:0] ack_take;
  logic             gate_open;
  logic             en_after;
  logic [31:0]      rd_d;
  logic             reeval_d;
  logic             eoi_go;

  cpuif_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(acc_addr), .wr(acc_write), .sel(sel), .err(dec_err)
  );

  assign gate_open = dist_en & en_v[acc_core];
  assign eoi_go    = acc_valid & acc_write & (sel == REG_EOI);

  generate
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_slot
      logic hit;
      assign hit         = acc_valid & (acc_core == CORE_W'(c));
      assign ack_take[c] = hit & !acc_write & (sel == REG_ACK) & gate_open;
      cpuif_core_slot #(.PRI_W(PRI_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctl  (hit & acc_write & (sel == REG_CTL)),
        .wr_pmr  (hit & acc_write & (sel == REG_PMR)),
        .wr_bpr  (hit & acc_write & (sel == REG_BPR)),
        .wdata   (acc_wdata[PRI_W-1:0]),
        .ack_take(ack_take[c]),
        .hp_load (hp_load[c]),
        .hp_id   (hp_id[c*ID_W +: ID_W]),
        .hp_src  (hp_src[c*SRC_W +: SRC_W]),
        .en      (en_v[c]),
        .pmr     (pmr_v[c]),
        .bpr     (bpr_v[c]),
        .rec_id  (id_v[c]),
        .rec_src (src_v[c]),
        .irq     (irq_out[c])
      );
    end
  endgenerate

  cpuif_eoi #(.CORE_W(CORE_W)) u_eoi (
    .clk     (clk),
    .rst_n   (rst_n),
    .eoi_go  (eoi_go),
    .core    (acc_core),
    .wdata   (acc_wdata[SRC_LSB+SRC_W-1:0]),
    .sgi_mask(sgi_clr_mask),
    .act_vld (act_clr_vld),
    .act_id  (act_clr_id)
  );

  always_comb begin
    rd_d = '0;
    if (acc_valid && !acc_write) begin
      case (sel)
        REG_CTL:  rd_d = {31'd0, en_v[acc_core]};
        REG_PMR:  rd_d = 32'(pmr_v[acc_core]);
        REG_BPR:  rd_d = 32'(bpr_v[acc_core]);
        REG_ACK:  rd_d = gate_open ? {{PAD_W{1'b0}}, src_v[acc_core], id_v[acc_core]}
                                   : 32'(SPUR_ID);
        REG_RPR:  rd_d = 32'(run_pri[acc_core*PRI_W +: PRI_W]);
        default:  rd_d = '0;
      endcase
    end
    en_after = (sel == REG_CTL && acc_write) ? acc_wdata[0] : en_v[acc_core];
    reeval_d = acc_valid && !dec_err &&
               ((acc_write && en_after) || (|ack_take));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      reeval    <= 1'b0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_rdata <= rd_d;
      rsp_err   <= acc_valid & dec_err;
      reeval    <= reeval_d;
    end
  end
endmodule

// File: rtl/cpuif_ack_chk.sv
module cpuif_ack_chk #(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 dist_en,
  input logic                 acc_valid,
  input logic                 acc_write,
  input logic [CORE_W-1:0]    acc_core,
  input logic [ADDR_W-1:0]    acc_addr,
  input logic [NUM_CORES-1:0] core_en,
  input logic                 rsp_valid,
  input logic [31:0]          rsp_rdata,
  input logic                 rsp_err,
  input logic [NUM_CORES-1:0] irq_out,
  input logic                 reeval,
  input logic [63:0]          sgi_clr_mask,
  input logic                 act_clr_vld,
  input logic [9:0]           act_clr_id
);
  logic ack_rd;
  assign ack_rd = acc_valid && !acc_write && (acc_addr == ADDR_W'(8'h0C));

  // R4
  ack_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd && dist_en && core_en[acc_core] |=> !irq_out[$past(acc_core)] && reeval);

  // R3
  gated_ack_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd && !(dist_en && core_en[acc_core]) |=> rsp_rdata == 32'd1023);

  // R7
  sgi_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sgi_clr_mask));

  // R8
  act_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_clr_vld |-> sgi_clr_mask == 64'd0 && act_clr_id >= 10'd16);

  // R10
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_rdata == 32'd0 && !reeval && sgi_clr_mask == 64'd0 && !act_clr_vld);

  // R12
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);

  // R12
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid);
endmodule

bind cpuif_ack cpuif_ack_chk #(
  .NUM_CORES(NUM_CORES), .CORE_W(CORE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .acc_valid(acc_valid),
  .acc_write(acc_write), .acc_core(acc_core), .acc_addr(acc_addr),
  .core_en(en_v), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .rsp_err(rsp_err), .irq_out(irq_out), .reeval(reeval),
  .sgi_clr_mask(sgi_clr_mask), .act_clr_vld(act_clr_vld), .act_clr_id(act_clr_id)
);

// File: tb/cpuif_ack_bench.sv
module cpuif_ack_bench;
  localparam int NC = 4;
  localparam int PW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, dist_en, acc_valid, acc_write;
  logic [1:0] acc_core;
  logic [7:0] acc_addr;
  logic [31:0] acc_wdata;
  logic [NC-1:0] hp_load;
  logic [NC*10-1:0] hp_id;
  logic [NC*3-1:0] hp_src;
  logic [NC*PW-1:0] run_pri;
  logic rsp_valid, rsp_err, reeval, act_clr_vld;
  logic [31:0] rsp_rdata;
  logic [NC-1:0] irq_out;
  logic [63:0] sgi_clr_mask;
  logic [9:0] act_clr_id;

  cpuif_ack #(.NUM_CORES(NC), .PRI_W(PW), .ADDR_W(8)) u_cpuif_ack (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit       m_en [NC];
  logic [7:0] m_pmr [NC];
  logic [2:0] m_bpr [NC];
  logic [9:0] m_id [NC];
  logic [2:0] m_src [NC];
  bit       m_irq [NC];

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] rp(int c);
    return 8'(8'h10 * c + 3);
  endfunction

  function automatic bit is_err(bit wr, logic [7:0] a);
    case (a)
      8'h00, 8'h04, 8'h08: return 0;
      8'h0C, 8'h14, 8'h1C: return wr;
      8'h10:               return !wr;
      default:             return 1;
    endcase
  endfunction

  task automatic step(bit av, bit wr, int core, logic [7:0] addr, logic [31:0] wd,
                      bit de, bit ld, int lc, logic [9:0] lid, logic [2:0] lsrc,
                      string tag);
    logic [31:0] e_rd;
    logic [63:0] e_mask;
    bit e_err, e_re, e_act, ok;
    logic [9:0] e_aid;
    logic [NC-1:0] e_irq;
    e_rd = 0; e_mask = 0; e_err = 0; e_re = 0; e_act = 0; e_aid = 0; ok = 0;
    if (av) begin
      e_err = is_err(wr, addr);
      if (!e_err && wr) begin
        e_re = (addr == 8'h00) ? wd[0] : m_en[core];
        if (addr == 8'h10) begin
          if (wd[9:0] < 16) e_mask = 64'd1 << (core + 8 * wd[12:10]);
          else begin e_act = 1; e_aid = wd[9:0]; end
        end
      end else if (!e_err) begin
        case (addr)
          8'h00: e_rd = {31'd0, m_en[core]};
          8'h04: e_rd = {24'd0, m_pmr[core]};
          8'h08: e_rd = {29'd0, m_bpr[core]};
          8'h14: e_rd = {24'd0, rp(core)};
          8'h0C: if (de && m_en[core]) begin
                   ok = 1; e_re = 1; e_rd = {19'd0, m_src[core], m_id[core]};
                 end else e_rd = 32'd1023;
          default: e_rd = 0;
        endcase
      end
    end
    @(negedge clk);
    dist_en = de; acc_valid = av; acc_write = wr; acc_core = 2'(core);
    acc_addr = addr; acc_wdata = wd;
    hp_load = '0;
    if (ld) begin
      hp_load[lc] = 1'b1;
      hp_id[lc*10 +: 10] = lid;
      hp_src[lc*3 +: 3] = lsrc;
    end
    @(posedge clk); #1;
    acc_valid = 0; hp_load = '0;
    chk({tag, " R12 rsp_valid"}, 64'(rsp_valid), 64'(av));
    chk({tag, " rdata"}, 64'(rsp_rdata), 64'(e_rd));
    chk({tag, " R10 err"}, 64'(rsp_err), 64'(e_err));
    chk({tag, " R9 reeval"}, 64'(reeval), 64'(e_re));
    chk({tag, " R7 sgi mask"}, sgi_clr_mask, e_mask);
    chk({tag, " R8 act"}, {53'd0, act_clr_vld, act_clr_id}, {53'd0, e_act, e_aid});
    if (av && !e_err && wr) begin
      if (addr == 8'h00) m_en[core] = wd[0];
      if (addr == 8'h04) m_pmr[core] = wd[7:0];
      if (addr == 8'h08) m_bpr[core] = wd[2:0];
    end
    if (ok) begin m_id[core] = 10'd1023; m_src[core] = 0; m_irq[core] = 0; end
    if (ld && !(ok && lc == core)) begin
      m_id[lc] = lid; m_src[lc] = lsrc; m_irq[lc] = (lid != 10'd1023);
    end
    for (int c = 0; c < NC; c++) e_irq[c] = m_irq[c];
    chk({tag, " R5 irq"}, 64'(irq_out), 64'(e_irq));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] a;
    logic [31:0] wd;
    bit wr;
    int op, cr;
    void'($urandom(32'd4242));
    for (int c = 0; c < NC; c++) begin
      m_en[c] = 0; m_pmr[c] = 0; m_bpr[c] = 0; m_id[c] = 10'd1023; m_src[c] = 0; m_irq[c] = 0;
      run_pri[c*PW +: PW] = rp(c);
    end
    rst_n = 0; dist_en = 1; acc_valid = 0; acc_write = 0; acc_core = 0;
    acc_addr = 0; acc_wdata = 0; hp_load = 0; hp_id = '0; hp_src = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 irq after reset", 64'(irq_out), 0);
    chk("R11 rsp after reset", {rsp_valid, rsp_err, reeval, act_clr_vld}, 0);
    chk("R11 mask after reset", sgi_clr_mask, 0);
    @(negedge clk); rst_n = 1;
    step(1, 0, 1, 8'h04, 0, 1, 0, 0, 0, 0, "R11 pmr reset");
    step(1, 0, 2, 8'h00, 0, 1, 0, 0, 0, 0, "R11 ctl reset");
    // enable core0, then its record still reads spurious
    step(1, 1, 0, 8'h00, 32'h1, 1, 0, 0, 0, 0, "R1 R9 ctl write");
    step(1, 0, 0, 8'h0C, 0, 1, 0, 0, 0, 0, "R11 R3 ack spurious after reset");
    step(1, 1, 2, 8'h04, 32'hA5, 1, 0, 0, 0, 0, "R9 pmr write disabled");
    step(1, 0, 2, 8'h04, 0, 1, 0, 0, 0, 0, "R1 pmr read");
    step(1, 1, 2, 8'h08, 32'hFF, 1, 0, 0, 0, 0, "R1 bpr write");
    step(1, 0, 2, 8'h08, 0, 1, 0, 0, 0, 0, "R1 bpr read");
    step(1, 0, 3, 8'h14, 0, 1, 0, 0, 0, 0, "R2 running priority");
    step(1, 0, 3, 8'h1C, 0, 1, 0, 0, 0, 0, "R2 ident");
    // load and acknowledge
    step(0, 0, 0, 0, 0, 1, 1, 0, 10'd37, 3'd0, "R5 load core0");
    step(1, 0, 0, 8'h0C, 0, 1, 0, 0, 0, 0, "R3 R4 ack core0");
    step(1, 0, 0, 8'h0C, 0, 1, 0, 0, 0, 0, "R4 ack after consume");
    step(0, 0, 0, 0, 0, 1, 1, 2, 10'd1023, 3'd0, "R5 load spurious");
    // gating
    step(0, 0, 0, 0, 0, 1, 1, 1, 10'd5, 3'd2, "R5 load core1");
    step(1, 0, 1, 8'h0C, 0, 1, 0, 0, 0, 0, "R3 ack core disabled");
    step(1, 1, 1, 8'h00, 32'h1, 1, 0, 0, 0, 0, "R9 enable core1");
    step(1, 0, 1, 8'h0C, 0, 0, 0, 0, 0, 0, "R3 ack dist disabled");
    step(1, 0, 1, 8'h0C, 0, 1, 0, 0, 0, 0, "R3 ack granted with source");
    // same-cycle load and acknowledge
    step(0, 0, 0, 0, 0, 1, 1, 1, 10'd41, 3'd0, "R5 load core1 again");
    step(1, 0, 1, 8'h0C, 0, 1, 1, 1, 10'd40, 3'd0, "R6 ack vs load");
    step(1, 0, 1, 8'h0C, 0, 1, 0, 0, 0, 0, "R6 ack after collision");
    // end of interrupt
    step(1, 1, 3, 8'h10, {19'd0, 3'd5, 10'd3}, 1, 0, 0, 0, 0, "R7 eoi sgi");
    step(1, 1, 3, 8'h10, {19'd0, 3'd7, 10'd15}, 1, 0, 0, 0, 0, "R7 eoi top bit");
    step(1, 1, 0, 8'h10, {19'd0, 3'd1, 10'd16}, 1, 0, 0, 0, 0, "R8 eoi id16");
    step(1, 1, 0, 8'h10, {19'd0, 3'd0, 10'd900}, 1, 0, 0, 0, 0, "R8 eoi id900");
    // errors
    step(1, 0, 2, 8'h18, 0, 1, 0, 0, 0, 0, "R10 hppi read");
    step(1, 1, 2, 8'h40, 32'h77, 1, 0, 0, 0, 0, "R10 unmapped write");
    step(1, 1, 0, 8'h0C, 32'h1, 1, 0, 0, 0, 0, "R10 write to ack");
    step(1, 0, 0, 8'h10, 0, 1, 0, 0, 0, 0, "R10 read eoi");
    step(1, 0, 2, 8'h04, 0, 1, 0, 0, 0, 0, "R10 pmr unchanged");
    // random mix
    for (int i = 0; i < 500; i++) begin
      op = $urandom_range(0, 9);
      cr = $urandom_range(0, NC - 1);
      wd = $urandom;
      wr = 0;
      case (op)
        0: begin wr = 1; a = 8'h00; wd[0] = ($urandom_range(0, 3) != 0); end
        1: begin wr = 1; a = 8'h04; end
        2: begin wr = 1; a = 8'h08; end
        3: a = 8'(4 * $urandom_range(0, 2));
        4: a = 8'h14;
        5: a = 8'h1C;
        6, 7: a = 8'h0C;
        8: begin wr = 1; a = 8'h10;
                 if ($urandom_range(0, 1) != 0) wd[9:0] = 10'($urandom_range(0, 15)); end
        default: begin wr = 1'($urandom_range(0, 1)); a = 8'h18 + 8'(4 * $urandom_range(0, 20)); end
      endcase
      step(1, wr, cr, a, wd, ($urandom_range(0, 9) != 0), 1'($urandom_range(0, 1)),
           $urandom_range(0, NC - 1),
           ($urandom_range(0, 3) == 0) ? 10'd1023 : 10'($urandom_range(0, 1022)),
           3'($urandom_range(0, 7)), "R1 R3 R4 R6 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule